// File: doc/BRIEF.md
# Atomic Context-Enable Set/Clear Unit

This execution-stage unit carries out one indivisible read-modify-write on a privileged control register. That register holds a global bit which lets all eligible hardware contexts run at the same time. The unit has one instruction strobe. On that strobe it returns the whole old register value for a general-register writeback. In the same result cycle it also produces the new register image, with the enable bit set or cleared. Both results come from one sampled copy of the register. Nothing can come between the read and the update, and no temporary register is needed.

The target register is fixed at privileged register number 0, select 1, and the instruction does not supply it. Two checks guard the operation. Privileged coprocessor access must be enabled, or the unit raises a coprocessor-unusable exception for coprocessor 0. The multi-context feature must be present, or the unit raises a reserved-instruction exception. A context that is not the master still gets the old value back, but its update strobe is held low. A destination of register 0 throws away the returned value. A later read of the register in the same instruction stream sees the new bit only after a hazard barrier, and that barrier is the pipeline's job, not this unit's.

Top module: `ctxen_rmw_unit`

## Requirements
- R1: During reset, and in the cycle right after reset, `wb_valid`, `ctl_we` and `exc_valid` are 0.
- R2: An instruction accepted at a clock edge (with access enabled, the feature present and `instr_rt` not 0) gives `wb_valid`=1, `wb_index`=`instr_rt` and `wb_data` equal to the `ctl_value` sampled at that edge. These appear in the cycle after that edge.
- R3: When `instr_rt` is 0, `wb_valid` stays 0 and `wb_data` is 0. The register update still happens as it would for any other destination.
- R4: With `instr_sc`=1 from a master context, `ctl_we`=1 and bit `EN_POS` of `ctl_next` (bit 0 by default) is 1.
- R5: With `instr_sc`=0 from a master context, `ctl_we`=1 and bit `EN_POS` of `ctl_next` is 0.
- R6: Every bit of `ctl_next` other than `EN_POS` equals the same bit of the sampled `ctl_value`.
- R7: When `ctx_master`=0, `ctl_we` stays 0 and `ctl_next` is 0. The writeback of R2 still happens.
- R8: When `cop_access_en`=0, `exc_valid`=1, `exc_code`=11 and `exc_cop`=0, whatever `feat_present` is. In that case `wb_valid` and `ctl_we` stay 0.
- R9: When `cop_access_en`=1 and `feat_present`=0, `exc_valid`=1, `exc_code`=10 and `exc_cop`=0. In that case `wb_valid` and `ctl_we` stay 0.
- R10: If no instruction is accepted at an edge, all three strobes are 0 in the next cycle. While no exception is raised, `exc_code` is 0.
- R11: `ctl_regnum` is always 0 and `ctl_sel` is always 1.
- R12: Instructions issued on back-to-back cycles each produce their own results, one cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_sc | input | 1 | 1 = set the enable bit, 0 = clear it |
| instr_rt | input | REG_AW | Destination general register |
| cop_access_en | input | 1 | Privileged coprocessor access enabled |
| feat_present | input | 1 | Multi-context feature implemented |
| ctx_master | input | 1 | Executing context holds master permission |
| ctl_value | input | DATA_W | Current control register value |
| wb_valid | output | 1 | Writeback strobe |
| wb_index | output | REG_AW | Writeback register index |
| wb_data | output | DATA_W | Old control value for writeback |
| ctl_we | output | 1 | Control register write strobe |
| ctl_next | output | DATA_W | New control register image |
| ctl_regnum | output | 5 | Target register number (always 0) |
| ctl_sel | output | 3 | Target register select (always 1) |
| exc_valid | output | 1 | Exception strobe |
| exc_code | output | 5 | Exception cause code |
| exc_cop | output | 2 | Coprocessor number reported with the exception |

## Verification
The hardest case to reach is the one where the flags disagree. A non-master context, or one whose destination is register 0, must take one half of the read-modify-write and not the other. A swapped or dropped gate could easily hide in that case. To reach it, the stimulus sweeps every combination of set/clear, access, feature and master flags. It does this with register values whose other bits are dense and uneven, so that pass-through errors show up. It then adds register-0 destinations and instructions issued back to back.

// File: rtl/ctxen_pkg.sv
package ctxen_pkg;
  localparam int unsigned EXC_W = 5;
  localparam int unsigned COP_W = 2;

  typedef enum logic [EXC_W-1:0] {
    EXC_NONE = 5'd0,
    EXC_RI   = 5'd10,
    EXC_CPU  = 5'd11
  } exc_code_e;

  localparam logic [4:0] CTL_REGNUM = 5'd0;
  localparam logic [2:0] CTL_SEL    = 3'd1;
  localparam logic [COP_W-1:0] EXC_COP_NUM = '0;

  // Fault priority: missing access outranks missing feature.
  function automatic exc_code_e pick_fault(input logic access_ok, input logic feat_ok);
    if (!access_ok)    return EXC_CPU;
    else if (!feat_ok) return EXC_RI;
    else               return EXC_NONE;
  endfunction
endpackage

// File: rtl/ctxen_fault_decode.sv
module ctxen_fault_decode
  import ctxen_pkg::*;
(
  input  logic             cop_access_en,
  input  logic             feat_present,
  output logic             fault_any,
  output logic [EXC_W-1:0] fault_code
);
  exc_code_e code_sel;

  always_comb begin
    code_sel   = pick_fault(cop_access_en, feat_present);
    fault_code = code_sel;
    fault_any  = (code_sel != EXC_NONE);
  end
endmodule

// File: rtl/ctxen_bit_merge.sv
module ctxen_bit_merge #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_POS = 0
) (
  input  logic [DATA_W-1:0] old_value,
  input  logic              set_not_clear,
  output logic [DATA_W-1:0] new_value
);
  localparam logic [DATA_W-1:0] EN_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << EN_POS;

  function automatic logic [DATA_W-1:0] apply_bit(input logic [DATA_W-1:0] v, input logic s);
    return s ? (v | EN_MASK) : (v & ~EN_MASK);
  endfunction

  assign new_value = apply_bit(old_value, set_not_clear);
endmodule

// File: rtl/ctxen_result_reg.sv
module ctxen_result_reg
  import ctxen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_fire,
  input  logic [REG_AW-1:0] wb_idx_in,
  input  logic [DATA_W-1:0] wb_data_in,
  input  logic              upd_fire,
  input  logic [DATA_W-1:0] upd_data_in,
  input  logic              exc_fire,
  input  logic [EXC_W-1:0]  exc_code_in,
  output logic              wb_valid,
  output logic [REG_AW-1:0] wb_index,
  output logic [DATA_W-1:0] wb_data,
  output logic              ctl_we,
  output logic [DATA_W-1:0] ctl_next,
  output logic              exc_valid,
  output logic [EXC_W-1:0]  exc_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_index  <= '0;
      wb_data   <= '0;
      ctl_we    <= 1'b0;
      ctl_next  <= '0;
      exc_valid <= 1'b0;
      exc_code  <= '0;
    end else begin
      wb_valid  <= wb_fire;
      wb_index  <= wb_fire  ? wb_idx_in   : '0;
      wb_data   <= wb_fire  ? wb_data_in  : '0;
      ctl_we    <= upd_fire;
      ctl_next  <= upd_fire ? upd_data_in : '0;
      exc_valid <= exc_fire;
      exc_code  <= exc_fire ? exc_code_in : '0;
    end
  end
endmodule

// File: rtl/ctxen_rmw_unit.sv
module ctxen_rmw_unit
  import ctxen_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_POS = 0,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic              instr_sc,
  input  logic [REG_AW-1:0] instr_rt,
  input  logic              cop_access_en,
  input  logic              feat_present,
  input  logic              ctx_master,
  input  logic [DATA_W-1:0] ctl_value,
  output logic              wb_valid,
  output logic [REG_AW-1:0] wb_index,
  output logic [DATA_W-1:0] wb_data,
  output logic              ctl_we,
  output logic [DATA_W-1:0] ctl_next,
  output logic [4:0]        ctl_regnum,
  output logic [2:0]        ctl_sel,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic [1:0]        exc_cop
);
  // Named internal events, visible to the bound checker.
  logic              fault_any;
  logic [EXC_W-1:0]  fault_code;
  logic [DATA_W-1:0] merged_value;
  logic              wb_allowed;
  logic              upd_allowed;
  logic              exc_fire;

  ctxen_fault_decode u_fault (
    .cop_access_en (cop_access_en),
    .feat_present  (feat_present),
    .fault_any     (fault_any),
    .fault_code    (fault_code)
  );

  ctxen_bit_merge #(.DATA_W(DATA_W), .EN_POS(EN_POS)) u_merge (
    .old_value     (ctl_value),
    .set_not_clear (instr_sc),
    .new_value     (merged_value)
  );

  assign wb_allowed  = instr_valid && !fault_any && (instr_rt != '0);
  assign upd_allowed = instr_valid && !fault_any && ctx_master;
  assign exc_fire    = instr_valid && fault_any;

  ctxen_result_reg #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .wb_fire     (wb_allowed),
    .wb_idx_in   (instr_rt),
    .wb_data_in  (ctl_value),
    .upd_fire    (upd_allowed),
    .upd_data_in (merged_value),
    .exc_fire    (exc_fire),
    .exc_code_in (fault_code),
    .wb_valid    (wb_valid),
    .wb_index    (wb_index),
    .wb_data     (wb_data),
    .ctl_we      (ctl_we),
    .ctl_next    (ctl_next),
    .exc_valid   (exc_valid),
    .exc_code    (exc_code)
  );

  assign ctl_regnum = CTL_REGNUM;
  assign ctl_sel    = CTL_SEL;
  assign exc_cop    = EXC_COP_NUM;
endmodule

// File: rtl/ctxen_rmw_checker.sv
module ctxen_rmw_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned EN_POS = 0,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic              instr_sc,
  input logic              cop_access_en,
  input logic              feat_present,
  input logic              ctx_master,
  input logic [DATA_W-1:0] ctl_value,
  input logic              wb_valid,
  input logic [REG_AW-1:0] wb_index,
  input logic              ctl_we,
  input logic [DATA_W-1:0] ctl_next,
  input logic              exc_valid,
  input logic [4:0]        exc_code
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~({{(DATA_W-1){1'b0}}, 1'b1} << EN_POS);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!wb_valid && !ctl_we && !exc_valid));

  assert_rt_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_index != '0));

  assert_set_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ctl_we && $past(instr_sc)) |-> ctl_next[EN_POS]);

  assert_clear_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ctl_we && !$past(instr_sc)) |-> !ctl_next[EN_POS]);

  assert_keep_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ctl_we) |-> ((ctl_next & KEEP_MASK) == ($past(ctl_value) & KEEP_MASK)));

  assert_no_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(instr_valid && !ctx_master)) |-> !ctl_we);

  assert_cpu_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(instr_valid && !cop_access_en)) |-> (exc_valid && exc_code == 5'd11));

  assert_ri_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(instr_valid && cop_access_en && !feat_present))
      |-> (exc_valid && exc_code == 5'd10));

  assert_exc_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!wb_valid && !ctl_we));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(instr_valid)) |-> (!wb_valid && !ctl_we && !exc_valid));
endmodule

bind ctxen_rmw_unit ctxen_rmw_checker #(.DATA_W(DATA_W), .EN_POS(EN_POS), .REG_AW(REG_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_sc      (instr_sc),
  .cop_access_en (cop_access_en),
  .feat_present  (feat_present),
  .ctx_master    (ctx_master),
  .ctl_value     (ctl_value),
  .wb_valid      (wb_valid),
  .wb_index      (wb_index),
  .ctl_we        (ctl_we),
  .ctl_next      (ctl_next),
  .exc_valid     (exc_valid),
  .exc_code      (exc_code)
);

// File: tb/ctxen_rmw_unit_bench.sv
module ctxen_rmw_unit_bench;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned EN_POS = 0;
  localparam int unsigned REG_AW = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              instr_valid = 1'b0;
  logic              instr_sc = 1'b0;
  logic [REG_AW-1:0] instr_rt = '0;
  logic              cop_access_en = 1'b0;
  logic              feat_present = 1'b0;
  logic              ctx_master = 1'b0;
  logic [DATA_W-1:0] ctl_value = '0;
  logic              wb_valid;
  logic [REG_AW-1:0] wb_index;
  logic [DATA_W-1:0] wb_data;
  logic              ctl_we;
  logic [DATA_W-1:0] ctl_next;
  logic [4:0]        ctl_regnum;
  logic [2:0]        ctl_sel;
  logic              exc_valid;
  logic [4:0]        exc_code;
  logic [1:0]        exc_cop;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctxen_rmw_unit #(.DATA_W(DATA_W), .EN_POS(EN_POS), .REG_AW(REG_AW)) u_ctxen_rmw_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_sc(instr_sc),
    .instr_rt(instr_rt), .cop_access_en(cop_access_en), .feat_present(feat_present),
    .ctx_master(ctx_master), .ctl_value(ctl_value), .wb_valid(wb_valid),
    .wb_index(wb_index), .wb_data(wb_data), .ctl_we(ctl_we), .ctl_next(ctl_next),
    .ctl_regnum(ctl_regnum), .ctl_sel(ctl_sel), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_cop(exc_cop)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected outcome computed from the requirements alone.
  task automatic check_result(input string req, input logic sc, input logic [REG_AW-1:0] rt,
                              input logic acc, input logic feat, input logic mst,
                              input logic [DATA_W-1:0] val);
    logic ok;
    logic [4:0] ecode;
    logic [DATA_W-1:0] nv;
    ok    = acc && feat;
    ecode = !acc ? 5'd11 : (!feat ? 5'd10 : 5'd0);
    nv    = val;
    nv[EN_POS] = sc;
    check(req, "exc_valid", 64'(exc_valid), 64'(!ok));
    check(req, "exc_code",  64'(exc_code), 64'(ecode));
    check(req, "exc_cop",   64'(exc_cop), 64'd0);
    check(req, "wb_valid",  64'(wb_valid), 64'(ok && rt != 0));
    check(req, "wb_index",  64'(wb_index), (ok && rt != 0) ? 64'(rt) : 64'd0);
    check(req, "wb_data",   64'(wb_data), (ok && rt != 0) ? 64'(val) : 64'd0);
    check(req, "ctl_we",    64'(ctl_we), 64'(ok && mst));
    check(req, "ctl_next",  64'(ctl_next), (ok && mst) ? 64'(nv) : 64'd0);
  endtask

  task automatic drive(input logic sc, input logic [REG_AW-1:0] rt, input logic acc,
                       input logic feat, input logic mst, input logic [DATA_W-1:0] val);
    instr_valid = 1'b1; instr_sc = sc; instr_rt = rt;
    cop_access_en = acc; feat_present = feat; ctx_master = mst; ctl_value = val;
  endtask

  task automatic issue(input string req, input logic sc, input logic [REG_AW-1:0] rt,
                       input logic acc, input logic feat, input logic mst,
                       input logic [DATA_W-1:0] val);
    @(negedge clk);
    drive(sc, rt, acc, feat, mst, val);
    @(negedge clk);
    instr_valid = 1'b0;
    check_result(req, sc, rt, acc, feat, mst, val);
  endtask

  task automatic t_reset_R1;
    rst_n = 1'b0;
    instr_valid = 1'b1; cop_access_en = 1'b1; feat_present = 1'b1; ctx_master = 1'b1; instr_rt = 5'd3;
    repeat (3) @(negedge clk);
    check("R1", "wb_valid in reset", 64'(wb_valid), 64'd0);
    check("R1", "ctl_we in reset", 64'(ctl_we), 64'd0);
    check("R1", "exc_valid in reset", 64'(exc_valid), 64'd0);
    instr_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "strobes after reset", 64'({wb_valid, ctl_we, exc_valid}), 64'd0);
  endtask

  // Every sc x access x feature x master combination (R2 R4 R5 R6 R7 R8 R9).
  task automatic t_sweep;
    logic [DATA_W-1:0] pats [4];
    pats[0] = 32'hA5C3_96F0; pats[1] = 32'h5A3C_690F; pats[2] = 32'hFFFF_FFFE; pats[3] = 32'h0000_0001;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 16; c++)
        issue("R2/R4/R5/R6/R7/R8/R9", c[0], REG_AW'(c + 1), c[1], c[2], c[3],
              pats[p] ^ DATA_W'(c * 32'h0101_0101));
  endtask

  task automatic t_rt_zero_R3;
    issue("R3", 1'b1, '0, 1'b1, 1'b1, 1'b1, 32'h1234_5670);
    issue("R3", 1'b0, '0, 1'b1, 1'b1, 1'b1, 32'hFEDC_BA99);
    issue("R3", 1'b1, '0, 1'b1, 1'b1, 1'b0, 32'h0F0F_0F0E);
  endtask

  task automatic t_priority_R8;
    issue("R8", 1'b1, 5'd9, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    issue("R9", 1'b0, 5'd9, 1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic t_idle_R10;
    @(negedge clk);
    cop_access_en = 1'b1; feat_present = 1'b1; ctx_master = 1'b1; instr_rt = 5'd7;
    @(negedge clk);
    check("R10", "idle strobes", 64'({wb_valid, ctl_we, exc_valid}), 64'd0);
    check("R10", "idle exc_code", 64'(exc_code), 64'd0);
  endtask

  task automatic t_const_R11;
    check("R11", "ctl_regnum", 64'(ctl_regnum), 64'd0);
    check("R11", "ctl_sel", 64'(ctl_sel), 64'd1);
  endtask

  task automatic t_back_to_back_R12;
    @(negedge clk);
    drive(1'b1, 5'd4, 1'b1, 1'b1, 1'b1, 32'h8000_0000);
    @(negedge clk);
    check_result("R12", 1'b1, 5'd4, 1'b1, 1'b1, 1'b1, 32'h8000_0000);
    drive(1'b0, 5'd31, 1'b1, 1'b1, 1'b1, 32'h7777_7777);
    @(negedge clk);
    check_result("R12", 1'b0, 5'd31, 1'b1, 1'b1, 1'b1, 32'h7777_7777);
    drive(1'b1, 5'd2, 1'b0, 1'b1, 1'b1, 32'h0000_0000);
    @(negedge clk);
    instr_valid = 1'b0;
    check_result("R12", 1'b1, 5'd2, 1'b0, 1'b1, 1'b1, 32'h0000_0000);
  endtask

  initial begin
    t_reset_R1();
    t_const_R11();
    t_sweep();
    t_rt_zero_R3();
    t_priority_R8();
    t_idle_R10();
    t_back_to_back_R12();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule